// File: doc/BRIEF.md
# Byte-Level I2C Bus Master

This block is a single-master I2C controller that software steps through one byte at a time using four byte-wide registers: control, status, data and clock divider. Setting the master bit produces a START, each data write in transmit direction shifts one byte out (MSB first) and samples the slave's acknowledge, and each data read in receive direction returns the byte last taken off the bus and launches the next one. Clearing the master bit produces a STOP. Every finished byte raises a pending flag that can drive an interrupt line.

Both bus lines are open-drain. An output-enable of 1 pulls the line low, and 0 releases it. SDA is read back through a synchronising input. Each SCL bit is split into four equal quarters, and the divider register sets the length of a quarter. Arbitration, slave clock stretching, slave mode and repeated START are not part of the block.

Register offsets: 0 control, 1 status, 2 data, 3 divider. Control bits: bit0 enable, bit1 interrupt enable, bit2 master, bit3 transmit direction, bit4 no-acknowledge. Status bits: bit0 bus busy, bit1 byte pending, bit2 slave did not acknowledge, bit3 bus sequence in progress.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00, the divider reads 3, `irq` is 0, and both line enables are 0 (lines released).
- R2: Writing control with bit2 (master) rising while bit0 (enable) is 1 produces a START: SDA falls while SCL is high, and status bit0 (busy) reads 1. If enable is 0, there is no START and busy stays 0.
- R3: Writing the data register while bit3 (transmit) is 1 and the bus is held sends the byte MSB first. An address byte is the 7-bit slave address shifted left by one, with bit0 = 1 for read and 0 for write.
- R4: When a byte finishes, status bit1 (pending) becomes 1. After a transmitted byte, status bit2 reads 1 if the slave left SDA high in the acknowledge slot, and 0 if it pulled SDA low.
- R5: A status write with bit1 = 0 clears pending. A status write with bit1 = 1 leaves it set.
- R6: Clearing bit2 while the bus is owned produces a STOP (SDA rises while SCL is high). Busy then reads 0, and both line enables are 0.
- R7: In receive direction (bit3 = 0), the first data read returns a meaningless byte and starts reception. Each later data read while master is set returns the byte just received and starts the next one.
- R8: During reception, control bit4 = 1 leaves SDA released in the acknowledge slot (no acknowledge). Bit4 = 0 pulls SDA low (acknowledge).
- R9: `irq` equals pending AND control bit1.
- R10: A data-register access while status bit3 (in progress) is 1 is ignored: no extra byte reaches the bus.
- R11: If bit2 is cleared before the last data read, that read returns the last byte, a STOP follows, and no further reception starts.
- R12: Each quarter of an SCL bit lasts divider+1 clocks, so SCL stays high for 2*(divider+1) clocks per bit.
- R13: SDA changes while SCL is high only as a START (when the bus is free) or a STOP (when the bus is owned).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sensed SDA level |

## Verification
A corrupted bit-engine state shows up at the pins within one SCL quarter. It appears either as an SDA edge while SCL is high, which the per-clock bus monitor sorts into legal START or STOP only against its own model of bus ownership, or as a missing or extra byte at the slave model. A wrong shift or acknowledge state shows up at the end of the byte, in the data the slave model collects, the acknowledge history it records, or the NACK status bit. A stuck pending or enable flag shows up on `irq` on the very next clock.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [1:0] OFS_DIV  = 2'd3;

  localparam int CTRL_W   = 5;
  localparam int C_EN     = 0;
  localparam int C_IE     = 1;
  localparam int C_MS     = 2;
  localparam int C_TX     = 3;
  localparam int C_NAK    = 4;

  localparam int S_BUSY   = 0;
  localparam int S_PEND   = 1;
  localparam int S_NACK   = 2;
  localparam int S_ACT    = 3;

  localparam int BYTE_W   = 8;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_START,
    ENG_HOLD,
    ENG_BIT,
    ENG_STOP
  } eng_state_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q >= div_i);
  assign tick_o = wrap;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              cmd_tx_i,
  input  logic              cmd_rx_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              no_ack_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              done_o,
  output logic              nack_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output eng_state_e        state_o
);
  localparam int BITCNT_W = $clog2(BYTE_W + 1);
  localparam logic [BITCNT_W-1:0] ACK_SLOT = BITCNT_W'(BYTE_W);

  eng_state_e          state_q, state_d;
  logic [1:0]          q_q, q_d;
  logic [BITCNT_W-1:0] bit_q, bit_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic                rxm_q, rxm_d;
  logic                nak_q, nak_d;
  logic                nack_q, nack_d;
  logic                scl_oe_q, scl_oe_d;
  logic                sda_oe_q, sda_oe_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                sda_s;
  logic                ack_slot;

  // input synchroniser, depth set by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sda_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sda_i};
      end
    end
  endgenerate
  assign sda_s    = sync_q[SYNC_STAGES-1];
  assign ack_slot = (bit_q == ACK_SLOT);

  always_comb begin
    state_d  = state_q;
    q_d      = q_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    rxm_d    = rxm_q;
    nak_d    = nak_q;
    nack_d   = nack_q;
    scl_oe_d = scl_oe_q;
    sda_oe_d = sda_oe_q;
    done_o   = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        if (cmd_start_i) begin
          state_d = ENG_START;
          q_d     = 2'd0;
        end
      end
      ENG_HOLD: begin
        if (cmd_tx_i) begin
          state_d = ENG_BIT;
          q_d     = 2'd0;
          bit_d   = '0;
          sh_d    = tx_byte_i;
          rxm_d   = 1'b0;
        end else if (cmd_rx_i) begin
          state_d = ENG_BIT;
          q_d     = 2'd0;
          bit_d   = '0;
          rxm_d   = 1'b1;
          nak_d   = no_ack_i;
        end else if (cmd_stop_i) begin
          state_d = ENG_STOP;
          q_d     = 2'd0;
        end
      end
      ENG_START: begin
        if (tick_i) begin
          q_d = q_q + 2'd1;
          unique case (q_q)
            2'd0: begin scl_oe_d = 1'b0; sda_oe_d = 1'b0; end
            2'd1: sda_oe_d = 1'b1;
            2'd2: ;
            2'd3: begin scl_oe_d = 1'b1; state_d = ENG_HOLD; end
          endcase
        end
      end
      ENG_BIT: begin
        if (tick_i) begin
          q_d = q_q + 2'd1;
          unique case (q_q)
            2'd0: begin
              if (ack_slot) sda_oe_d = rxm_q ? !nak_q : 1'b0;
              else          sda_oe_d = rxm_q ? 1'b0 : !sh_q[BYTE_W-1];
            end
            2'd1: scl_oe_d = 1'b0;
            2'd2: begin
              if (!ack_slot)   sh_d   = {sh_q[BYTE_W-2:0], sda_s};
              else if (!rxm_q) nack_d = sda_s;
            end
            2'd3: begin
              scl_oe_d = 1'b1;
              if (ack_slot) begin
                state_d = ENG_HOLD;
                bit_d   = '0;
                done_o  = 1'b1;
              end else begin
                bit_d = bit_q + 1'b1;
              end
            end
          endcase
        end
      end
      ENG_STOP: begin
        if (tick_i) begin
          q_d = q_q + 2'd1;
          unique case (q_q)
            2'd0: sda_oe_d = 1'b1;
            2'd1: scl_oe_d = 1'b0;
            2'd2: sda_oe_d = 1'b0;
            2'd3: state_d  = ENG_IDLE;
          endcase
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      q_q      <= 2'd0;
      bit_q    <= '0;
      sh_q     <= '0;
      rxm_q    <= 1'b0;
      nak_q    <= 1'b0;
      nack_q   <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      q_q      <= q_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      rxm_q    <= rxm_d;
      nak_q    <= nak_d;
      nack_q   <= nack_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
    end
  end

  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;
  assign nack_o    = nack_q;
  assign rx_byte_o = sh_q;
  assign state_o   = state_q;

  // R10: byte/stop commands from the register side only land while the bus is held
  a_r10_cmd_only_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_tx_i || cmd_rx_i || cmd_stop_i) |-> (state_q == ENG_HOLD));

  // R6: with no sequence running both lines are released
  a_r6_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_IDLE) |-> (!scl_oe_q && !sda_oe_q));

  // R13: inside a bit, SDA never moves while SCL stays released
  a_r13_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_BIT && $past(state_q) == ENG_BIT && !scl_oe_q && !$past(scl_oe_q))
    |-> $stable(sda_oe_q));

  // R4: a finished byte always parks the bus with SCL low
  a_r4_done_parks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (state_q == ENG_HOLD && scl_oe_q));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  logic rst_meta_q, rst_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              pend_q, pend_d;
  logic              sreq_q, sreq_d;
  logic              preq_q, preq_d;

  logic              wr_ctrl, wr_stat, wr_data, wr_div, rd_data;
  logic              cmd_start, cmd_stop, cmd_tx, cmd_rx;
  logic              tick, done, eng_nack;
  logic [BYTE_W-1:0] rx_byte;
  eng_state_e        eng_state;
  logic              held, stat_busy, stat_act;
  logic [7:0]        stat_vec;

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_data = reg_wr && (reg_addr == OFS_DATA);
  assign wr_div  = reg_wr && (reg_addr == OFS_DIV);
  assign rd_data = reg_rd && (reg_addr == OFS_DATA);

  assign held      = (eng_state == ENG_HOLD);
  assign cmd_start = sreq_q && (eng_state == ENG_IDLE);
  assign cmd_stop  = preq_q && held;
  assign cmd_tx    = wr_data && ctrl_q[C_TX] && ctrl_q[C_MS] && held && !preq_q;
  assign cmd_rx    = rd_data && !ctrl_q[C_TX] && ctrl_q[C_MS] && held && !preq_q;

  always_comb begin
    ctrl_d = wr_ctrl ? reg_wdata[CTRL_W-1:0] : ctrl_q;
    div_d  = wr_div  ? reg_wdata[DIV_W-1:0]  : div_q;

    sreq_d = sreq_q;
    if (cmd_start) sreq_d = 1'b0;
    else if (wr_ctrl && reg_wdata[C_MS] && reg_wdata[C_EN] && !ctrl_q[C_MS]
             && eng_state == ENG_IDLE)
      sreq_d = 1'b1;

    preq_d = preq_q;
    if (cmd_stop) preq_d = 1'b0;
    else if (wr_ctrl && !reg_wdata[C_MS] && ctrl_q[C_MS]
             && (eng_state != ENG_IDLE || sreq_q))
      preq_d = 1'b1;

    pend_d = pend_q;
    if (done)                              pend_d = 1'b1;
    else if (wr_stat && !reg_wdata[S_PEND]) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q <= '0;
      div_q  <= DIV_INIT;
      pend_q <= 1'b0;
      sreq_q <= 1'b0;
      preq_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      pend_q <= pend_d;
      sreq_q <= sreq_d;
      preq_q <= preq_d;
    end
  end

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_q),
    .div_i  (div_q),
    .tick_o (tick)
  );

  i2cm_engine #(.SYNC_STAGES(2)) u_engine (
    .clk         (clk),
    .rst_n       (rst_q),
    .tick_i      (tick),
    .cmd_start_i (cmd_start),
    .cmd_stop_i  (cmd_stop),
    .cmd_tx_i    (cmd_tx),
    .cmd_rx_i    (cmd_rx),
    .tx_byte_i   (reg_wdata),
    .no_ack_i    (ctrl_q[C_NAK]),
    .sda_i       (sda_i),
    .scl_oe_o    (scl_oe),
    .sda_oe_o    (sda_oe),
    .done_o      (done),
    .nack_o      (eng_nack),
    .rx_byte_o   (rx_byte),
    .state_o     (eng_state)
  );

  assign stat_busy = sreq_q || (eng_state != ENG_IDLE);
  assign stat_act  = sreq_q || preq_q || (eng_state == ENG_START) ||
                     (eng_state == ENG_BIT) || (eng_state == ENG_STOP);

  always_comb begin
    stat_vec         = '0;
    stat_vec[S_BUSY] = stat_busy;
    stat_vec[S_PEND] = pend_q;
    stat_vec[S_NACK] = eng_nack;
    stat_vec[S_ACT]  = stat_act;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = 8'(ctrl_q);
      OFS_STAT: reg_rdata = stat_vec;
      OFS_DATA: reg_rdata = rx_byte;
      default:  reg_rdata = 8'(div_q);
    endcase
  end

  assign irq = pend_q && ctrl_q[C_IE];

  // R2: an issued START makes the bus read busy on the next clock
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_start |=> stat_busy);

  // R5: pending only falls through a clearing status write
  a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (pend_q && !(wr_stat && !reg_wdata[S_PEND])) |=> pend_q);
endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  localparam logic [6:0] SLV = 7'h42;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       s_pull = 1'b0;
  logic       scl_l, sda_l;

  int n_total = 0;
  int n_bad   = 0;

  always #2 clk = ~clk;

  assign scl_l = ~scl_oe;
  assign sda_l = ~(sda_oe | s_pull);

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_l)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural slave ----------------
  int         sbit = 0;
  int         sph  = 0;
  logic [7:0] ssh = 8'd0, rd_byte = 8'd0, addr_seen = 8'd0;
  logic       m_ack = 1'b0;
  byte unsigned wr_q[$];
  byte unsigned rd_q[$];
  bit         acks[$];

  function automatic logic [7:0] next_rd();
    if (rd_q.size() == 0) return 8'h00;
    return rd_q.pop_front();
  endfunction

  always @(negedge sda_l) if (scl_l === 1'b1) begin sph = 1; sbit = -1; end
  always @(posedge sda_l) if (scl_l === 1'b1) begin sph = 0; s_pull = 1'b0; end

  always @(posedge scl_l) if (sph != 0 && sbit >= 0) begin
    if (sbit < 8) ssh = {ssh[6:0], sda_l};
    else if (sph == 3) m_ack = !sda_l;
  end

  always @(negedge scl_l) if (sph != 0) begin
    if (sbit < 0) sbit = 0;
    else if (sbit == 7) begin
      sbit = 8;
      case (sph)
        1: if (ssh[7:1] == SLV) begin s_pull = 1'b1; addr_seen = ssh; end
           else sph = 0;
        2: begin wr_q.push_back(ssh); s_pull = 1'b1; end
        default: s_pull = 1'b0;
      endcase
    end else if (sbit == 8) begin
      sbit = 0;
      s_pull = 1'b0;
      if (sph == 1) begin
        if (addr_seen[0]) begin sph = 3; rd_byte = next_rd(); s_pull = ~rd_byte[7]; end
        else sph = 2;
      end else if (sph == 3) begin
        acks.push_back(m_ack);
        if (m_ack) begin rd_byte = next_rd(); s_pull = ~rd_byte[7]; end
        else sph = 4;
      end
    end else begin
      sbit++;
      if (sph == 3) s_pull = ~rd_byte[7 - sbit];
    end
  end

  // ---------------- per-clock bus reference ----------------
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  bit   owned = 1'b0;
  int   start_cnt = 0, stop_cnt = 0, hi_cnt = 0, last_hi = 0;
  bit   ie_sh = 1'b0, ie_prev = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_scl && scl_l && (sda_l != prev_sda)) begin
        if (!sda_l) begin
          chk("R13 start only on free bus", owned, 0);
          owned = 1'b1; start_cnt++;
        end else begin
          chk("R13 stop only on owned bus", owned, 1);
          owned = 1'b0; stop_cnt++;
        end
      end
      if (scl_l) hi_cnt++;
      else begin
        if (prev_scl) last_hi = hi_cnt;
        hi_cnt = 0;
      end
      if (!ie_sh && !ie_prev) chk("R9 irq low while disabled", irq, 0);
      ie_prev = ie_sh;
    end
    prev_scl = scl_l;
    prev_sda = sda_l;
  end

  // ---------------- register access ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) ie_sh = d[1];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_stat(input int b, input logic v, input string req);
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, s);
      if (s[b] == v) return;
    end
    chk(req, 0, 1);
  endtask

  localparam logic [7:0] EN = 8'h01, IE = 8'h02, MS = 8'h04, TX = 8'h08, NK = 8'h10;

  bit done_flag = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_total++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd3, v); chk("R1 divider", v, 3);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    // R2 no START without enable
    wr(2'd0, MS | TX);
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk("R2 busy without enable", v[0], 0);
    chk("R2 no start without enable", start_cnt, 0);
    wr(2'd0, 8'h00);

    // write transaction
    wr(2'd0, EN | IE | MS | TX | NK);
    rd(2'd1, v); chk("R2 busy after start", v[0], 1);
    wait_stat(3, 1'b0, "R2 start timeout");
    chk("R2 start seen", start_cnt, 1);
    wr(2'd2, {SLV, 1'b0});
    rd(2'd1, v); chk("R10 in progress", v[3], 1);
    wr(2'd2, 8'hFF);                      // R10 must be ignored
    wait_stat(1, 1'b1, "R4 address byte timeout");
    rd(2'd1, v); chk("R4 pending", v[1], 1); chk("R4 acked", v[2], 0);
    @(negedge clk); chk("R9 irq on pending", irq, 1);
    chk("R12 scl high default", last_hi, 8);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R5 write one keeps pending", v[1], 1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R5 write zero clears", v[1], 0);
    chk("R9 irq after clear", irq, 0);
    wr(2'd2, 8'hA5); wait_stat(1, 1'b1, "R3 byte timeout"); wr(2'd1, 8'h00);
    wr(2'd2, 8'h3C); wait_stat(1, 1'b1, "R3 byte timeout"); wr(2'd1, 8'h00);
    wr(2'd0, EN | IE | TX | NK);
    wait_stat(0, 1'b0, "R6 stop timeout");
    chk("R6 stop seen", stop_cnt, 1);
    chk("R6 lines released", {scl_oe, sda_oe}, 0);
    chk("R3 address byte", addr_seen, {SLV, 1'b0});
    chk("R10 byte count", wr_q.size(), 2);
    if (wr_q.size() == 2) begin
      chk("R3 first byte", wr_q[0], 8'hA5);
      chk("R3 second byte", wr_q[1], 8'h3C);
    end

    // unanswered address, faster clock
    wr(2'd3, 8'd1);
    wr(2'd0, EN | IE | MS | TX | NK);
    wait_stat(3, 1'b0, "R2 start timeout");
    wr(2'd2, {7'h13, 1'b0});
    wait_stat(1, 1'b1, "R4 nack byte timeout");
    rd(2'd1, v); chk("R4 nack flag", v[2], 1);
    chk("R12 scl high divider 1", last_hi, 4);
    wr(2'd1, 8'h00);
    wr(2'd0, EN | IE | TX | NK);
    wait_stat(0, 1'b0, "R6 stop timeout");

    // two-byte read
    rd_q.push_back(8'h5A); rd_q.push_back(8'hC3);
    wr(2'd0, EN | IE | MS | TX | NK);
    wait_stat(3, 1'b0, "R2 start timeout");
    wr(2'd2, {SLV, 1'b1});
    wait_stat(1, 1'b1, "R7 address timeout");
    rd(2'd1, v); chk("R4 read address acked", v[2], 0);
    wr(2'd1, 8'h00);
    wr(2'd0, EN | IE | MS);
    rd(2'd2, v);                          // dummy, starts first byte
    wait_stat(1, 1'b1, "R7 rx timeout"); wr(2'd1, 8'h00);
    wr(2'd0, EN | IE | MS | NK);
    rd(2'd2, v); chk("R7 first byte", v, 8'h5A);
    wait_stat(1, 1'b1, "R7 rx timeout"); wr(2'd1, 8'h00);
    wr(2'd0, EN | IE);
    rd(2'd2, v); chk("R11 last byte", v, 8'hC3);
    wait_stat(0, 1'b0, "R11 stop timeout");
    repeat (60) @(negedge clk);
    rd(2'd1, v); chk("R11 no further reception", v & 8'h0B, 8'h00);
    chk("R11 stop seen", stop_cnt, 3);
    chk("R8 ack history size", acks.size(), 2);
    if (acks.size() == 2) begin
      chk("R8 ack when bit4 clear", acks[0], 1);
      chk("R8 no ack when bit4 set", acks[1], 0);
    end

    // single-byte read
    rd_q.push_back(8'h77);
    wr(2'd0, EN | IE | MS | TX | NK);
    wait_stat(3, 1'b0, "R2 start timeout");
    wr(2'd2, {SLV, 1'b1});
    wait_stat(1, 1'b1, "R7 address timeout"); wr(2'd1, 8'h00);
    wr(2'd0, EN | IE | MS | NK);
    rd(2'd2, v);
    wait_stat(1, 1'b1, "R7 rx timeout"); wr(2'd1, 8'h00);
    wr(2'd0, EN | IE);
    rd(2'd2, v); chk("R7 single byte", v, 8'h77);
    wait_stat(0, 1'b0, "R11 stop timeout");
    chk("R8 single byte not acked", (acks.size() == 3) ? int'(acks[2]) : 9, 0);
    chk("R13 start total", start_cnt, 4);
    chk("R13 stop total", stop_cnt, 4);

    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule